// File: doc/BRIEF.md
# Trimmable Setting Counter with Stored Calibration

This block is the digital heart of a one-time trim for an output level. A three-level control input, already resolved into low, mid and high and brought into the clock domain, steps a 7-bit setting up or down. Keeping the control at its top level long enough commits the setting to a modelled nonvolatile cell. The setting drives the code of a downstream DAC.

An enable input qualifies every action. With enable high, the block is in adjust mode: steps are taken and a long high can write the cell. With enable low, the block is in read mode: the setting is reloaded from the cell every cycle and the control input is ignored. The enable pad is pulled down, so a pin left floating selects read mode. To verify a trim, program a value, move the setting away from it, drop enable and watch the setting come back.

Top module: `trim_ctrl_top`

## Requirements
- R1: During and straight after synchronous active-low reset, `code_o` is 64 (the value of the cell when it was never written) and `prog_o` is 0.
- R2: With enable high, a control move from mid (code 01) to high (code 10) raises `code_o` by one on the clock edge that samples the high code.
- R3: With enable high, a control move from mid (01) to low (code 00) lowers `code_o` by one on the clock edge that samples the low code.
- R4: The setting saturates: a raise at 127 leaves 127, and a lower at 0 leaves 0.
- R5: With enable high, holding the control at high for HOLD = CLK_HZ/1000*HOLD_MS consecutive sampled cycles writes the setting into the cell. On that same edge `prog_o` goes high for exactly one cycle. No further write occurs until the control has left high.
- R6: With enable low, `code_o` equals the stored value from the next edge on, control activity changes nothing, no write occurs and `prog_o` stays 0. An undriven enable is pulled low and behaves the same way.
- R7: Only moves that start at mid take a step: a direct low-to-high or high-to-low move leaves the setting unchanged. The unused code 11 is treated as mid.
- R8: After a value is programmed and the setting is then moved away, dropping enable returns `code_o` to the programmed value.
- R9: A high period broken by enable going low restarts the hold count. A later write needs a full new HOLD cycles of high with enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Adjust enable; low selects read mode |
| lvl_i | input | 2 | Control level: 00 low, 01 mid, 10 high, 11 treated as mid |
| code_o | output | 7 | Current setting (DAC code) |
| prog_o | output | 1 | One-cycle strobe when the cell is written |

## Verification
The setting is exercised in four ways:
- Alternating mid/high and mid/low steps separate raising from lowering and show the one-edge latency.
- Direct low-to-high moves and the unused code 11 show that only departures from mid count.
- Long runs of steps push the setting into both rails, which exposes any wrap-around.
- Hold periods of full length, of extended length and broken by enable show that the write fires exactly once per period, honours the full count, restarts after enable drops, and is blocked in read mode.

A cycle-level reference model in the bench predicts every output.

// File: rtl/trim_pkg.sv
// Shared level encoding for the trim controller.
// Assumes the control input is already synchronised to clk.
package trim_pkg;
    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_MID = 2'b01,
        LVL_HI  = 2'b10,
        LVL_RSV = 2'b11
    } lvl_e;

    // Map a raw level code to a valid level; the unused code counts as mid.
    function automatic lvl_e norm_lvl(input logic [1:0] raw);
        case (raw)
            2'b00:   return LVL_LO;
            2'b10:   return LVL_HI;
            default: return LVL_MID;
        endcase
    endfunction
endpackage

// File: rtl/trim_level_edge.sv
// Detects step moves of the three-level control.
// up_o: mid followed by high. dn_o: mid followed by low. hi_o: level is high now.
// Assumes lvl_i is synchronous. Reset leaves the history at low, so no step follows reset.
module trim_level_edge
    import trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       hi_o
);
    lvl_e cur_lvl;
    lvl_e prev_q;

    // Normalise the incoming code.
    always_comb cur_lvl = norm_lvl(lvl_i);

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= LVL_LO;
        else        prev_q <= cur_lvl;
    end

    // Decode step moves; only departures from mid count.
    always_comb begin
        up_o = (prev_q == LVL_MID) && (cur_lvl == LVL_HI);
        dn_o = (prev_q == LVL_MID) && (cur_lvl == LVL_LO);
        hi_o = (cur_lvl == LVL_HI);
    end
endmodule

// File: rtl/trim_hold_timer.sv
// Measures a continuous high period while enable is high.
// fire_o is raised on the HOLD_CYCLES-th consecutive qualifying cycle.
// It fires once per period; the level must leave high, or enable drop, to re-arm.
module trim_hold_timer #(
    parameter int HOLD_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hi_i,
    output logic fire_o
);
    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    logic armed_q;
    logic qualify;

    // A cycle counts only in adjust mode with the level high.
    always_comb qualify = en_i && hi_i;

    // Re-arm whenever the qualifying condition breaks; disarm after a fire.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed_q <= 1'b1;
        else if (!qualify)     armed_q <= 1'b1;
        else if (fire_o)       armed_q <= 1'b0;
    end

    generate
        if (HOLD_CYCLES <= 1) begin : g_immediate
            // A single qualifying cycle is enough.
            always_comb fire_o = qualify && armed_q;
        end else begin : g_counted
            logic [CNT_W-1:0] cnt_q;
            logic             at_end;

            // Terminal count reached on this cycle.
            always_comb at_end = (cnt_q == CNT_W'(HOLD_CYCLES - 1));

            // Count qualifying cycles of an armed period.
            always_ff @(posedge clk) begin
                if (!rst_n)                 cnt_q <= '0;
                else if (!qualify)          cnt_q <= '0;
                else if (armed_q && at_end) cnt_q <= '0;
                else if (armed_q)           cnt_q <= cnt_q + 1'b1;
            end

            // Fire on the last cycle of the period.
            always_comb fire_o = qualify && armed_q && at_end;
        end
    endgenerate
endmodule

// File: rtl/trim_nv_store.sv
// Behavioural model of the one-word nonvolatile cell.
// Reset restores the erased (never programmed) value; cell timing is not modelled.
module trim_nv_store #(
    parameter int CODE_W    = 7,
    parameter int INIT_CODE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wr_data_i,
    output logic [CODE_W-1:0] rd_data_o
);
    logic [CODE_W-1:0] cell_q;

    // Hold the stored word; write on request.
    always_ff @(posedge clk) begin
        if (!rst_n)    cell_q <= CODE_W'(INIT_CODE);
        else if (wr_i) cell_q <= wr_data_i;
    end

    // The stored word is always readable.
    always_comb rd_data_o = cell_q;
endmodule

// File: rtl/trim_step_counter.sv
// Saturating up/down setting counter with parallel load.
// The load wins over the steps. Assumes up_i and dn_i are never both high.
module trim_step_counter #(
    parameter int CODE_W    = 7,
    parameter int INIT_CODE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_data_i,
    input  logic              up_i,
    input  logic              dn_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    logic [CODE_W-1:0] code_q;

    // Load, or step with clamping at both rails.
    always_ff @(posedge clk) begin
        if (!rst_n)                             code_q <= CODE_W'(INIT_CODE);
        else if (load_i)                        code_q <= load_data_i;
        else if (up_i && (code_q != CODE_MAX))  code_q <= code_q + 1'b1;
        else if (dn_i && (code_q != CODE_MIN))  code_q <= code_q - 1'b1;
    end

    // Present the setting.
    always_comb code_o = code_q;
endmodule

// File: rtl/trim_ctrl_top.sv
// Trim controller top.
// Adjust mode (en_i high): the control steps the setting, and a long high stores it.
// Read mode (en_i low): the setting follows the stored word.
// Assumes en_i and lvl_i are synchronous to clk. The enable pad pull-down lives outside.
module trim_ctrl_top #(
    parameter int CODE_W    = 7,
    parameter int INIT_CODE = 64,
    parameter int CLK_HZ    = 50_000_000,
    parameter int HOLD_MS   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [1:0]        lvl_i,
    output logic [CODE_W-1:0] code_o,
    output logic              prog_o
);
    localparam int HOLD_CYCLES = (CLK_HZ / 1000) * HOLD_MS;

    logic              step_up, step_dn, lvl_hi;
    logic              wr_fire;
    logic [CODE_W-1:0] stored_code;
    logic [CODE_W-1:0] cur_code;
    logic              prog_q;

    trim_level_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl_i),
        .up_o  (step_up),
        .dn_o  (step_dn),
        .hi_o  (lvl_hi)
    );

    trim_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .hi_i   (lvl_hi),
        .fire_o (wr_fire)
    );

    trim_nv_store #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_fire),
        .wr_data_i (cur_code),
        .rd_data_o (stored_code)
    );

    trim_step_counter #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (!en_i),
        .load_data_i (stored_code),
        .up_i        (en_i && step_up),
        .dn_i        (en_i && step_dn),
        .code_o      (cur_code)
    );

    // Register the write strobe for a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b0;
        else        prog_q <= wr_fire;
    end

    // Drive outputs.
    always_comb begin
        code_o = cur_code;
        prog_o = prog_q;
    end
endmodule

// File: rtl/trim_ctrl_chk.sv
// Port-level property checker for trim_ctrl_top, attached with bind.
module trim_ctrl_chk
    import trim_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic [1:0]        lvl_i,
    input logic [CODE_W-1:0] code_o,
    input logic              prog_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    lvl_e cur_lvl;
    always_comb cur_lvl = norm_lvl(lvl_i);

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(rst_n) && cur_lvl == LVL_HI && $past(cur_lvl) == LVL_MID
         && code_o != CODE_MAX) |=> (code_o == $past(code_o) + 1'b1));

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(rst_n) && cur_lvl == LVL_LO && $past(cur_lvl) == LVL_MID
         && code_o != CODE_MIN) |=> (code_o == $past(code_o) - 1'b1));

    // R4
    top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && code_o == CODE_MAX) |=> (code_o >= CODE_MAX - 1'b1));

    // R4
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && code_o == CODE_MIN) |=> (code_o <= CODE_MIN + 1'b1));

    // R5
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |=> !prog_o);

    // R6
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !prog_o);

    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && $past(!en_i)) |=> $stable(code_o));
endmodule

bind trim_ctrl_top trim_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .lvl_i  (lvl_i),
    .code_o (code_o),
    .prog_o (prog_o)
);

// File: tb/tb_trim_ctrl_top.sv
module tb_trim_ctrl_top;
    localparam int HOLD = 200;  // (5000/1000)*40

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] lvl_i = 2'b00;
    logic [6:0] code_o;
    logic       prog_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    code;
        bit    prog;
        string tag;
    } exp_t;
    exp_t q[$];

    // Reference model state
    int m_prev = 0, m_cnt = 0, m_code = 64, m_nvm = 64;
    bit m_armed = 1'b1;

    trim_ctrl_top #(.CLK_HZ(5000), .HOLD_MS(40)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .lvl_i(lvl_i),
        .code_o(code_o), .prog_o(prog_o)
    );

    always #10 clk = ~clk;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted outputs.
    task automatic cyc(input bit en, input logic [1:0] lvl, input string tag);
        int  n;
        bit  fire;
        exp_t e;
        @(negedge clk);
        en_i  = en;
        lvl_i = lvl;
        n = (lvl == 2'b00) ? 0 : (lvl == 2'b10) ? 2 : 1;
        fire = en && (n == 2) && m_armed && (m_cnt == HOLD - 1);
        if (!en) begin
            m_code  = m_nvm;
            m_cnt   = 0;
            m_armed = 1'b1;
        end else begin
            if (fire) m_nvm = m_code;
            if (m_prev == 1 && n == 2 && m_code != 127) m_code++;
            else if (m_prev == 1 && n == 0 && m_code != 0) m_code--;
            if (n != 2) begin
                m_cnt = 0;
                m_armed = 1'b1;
            end else if (m_armed) begin
                if (fire) begin
                    m_cnt = 0;
                    m_armed = 1'b0;
                end else begin
                    m_cnt++;
                end
            end
        end
        m_prev = n;
        e.code = m_code;
        e.prog = fire;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic repeat_cyc(input int k, input bit en, input logic [1:0] lvl, input string tag);
        for (int i = 0; i < k; i++) cyc(en, lvl, tag);
    endtask

    // Monitor: compare outputs after each edge against the queue.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(int'(code_o), e.code, {e.tag, " code"});
            check(int'(prog_o), int'(e.prog), {e.tag, " prog"});
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check(int'(code_o), 64, "R1 reset code");
        check(int'(prog_o), 0, "R1 reset prog");
        @(negedge clk);
        rst_n = 1'b1;

        // R6: read mode ignores all control activity, even a long high
        repeat_cyc(2, 1'b0, 2'b01, "R6");
        cyc(1'b0, 2'b10, "R6");
        cyc(1'b0, 2'b01, "R6");
        cyc(1'b0, 2'b00, "R6");
        repeat_cyc(HOLD + 20, 1'b0, 2'b10, "R6");

        // R2 / R3: basic stepping
        repeat_cyc(2, 1'b1, 2'b01, "R2");
        cyc(1'b1, 2'b10, "R2");
        cyc(1'b1, 2'b01, "R2");
        cyc(1'b1, 2'b10, "R2");
        cyc(1'b1, 2'b01, "R3");
        cyc(1'b1, 2'b00, "R3");
        cyc(1'b1, 2'b01, "R3");

        // R7: direct moves do not step; code 11 acts as mid
        cyc(1'b1, 2'b00, "R7");
        cyc(1'b1, 2'b10, "R7");
        cyc(1'b1, 2'b00, "R7");
        cyc(1'b1, 2'b11, "R7");
        cyc(1'b1, 2'b10, "R7");
        cyc(1'b1, 2'b11, "R7");
        cyc(1'b1, 2'b00, "R7");

        // R4: drive into both rails
        for (int i = 0; i < 70; i++) begin
            cyc(1'b1, 2'b01, "R4");
            cyc(1'b1, 2'b10, "R4");
        end
        for (int i = 0; i < 132; i++) begin
            cyc(1'b1, 2'b01, "R4");
            cyc(1'b1, 2'b00, "R4");
        end

        // R5: program a value with a long high, only one write
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 2'b01, "R5");
            cyc(1'b1, 2'b10, "R5");
        end
        cyc(1'b1, 2'b01, "R5");
        repeat_cyc(2 * HOLD + 30, 1'b1, 2'b10, "R5");

        // R8: move away, then drop enable and expect the stored value
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 2'b01, "R8");
            cyc(1'b1, 2'b10, "R8");
        end
        repeat_cyc(5, 1'b0, 2'b01, "R8");

        // R9: an interrupted high period must start over
        cyc(1'b1, 2'b01, "R9");
        cyc(1'b1, 2'b10, "R9");
        repeat_cyc(HOLD - 20, 1'b1, 2'b10, "R9");
        repeat_cyc(3, 1'b0, 2'b10, "R9");
        repeat_cyc(HOLD - 1, 1'b1, 2'b10, "R9");
        repeat_cyc(5, 1'b1, 2'b10, "R9");
        cyc(1'b1, 2'b01, "R9");
        repeat_cyc(4, 1'b0, 2'b01, "R9");

        repeat (4) @(posedge clk);
        #3;
        check(q.size(), 0, "R1 queue drained");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule